// File: doc/BRIEF.md
# Three-Digit Decimal-Coded Input to Binary Converter

This block turns a packed three-digit decimal-coded number into its binary value, ready to be used as an operand by an 8-bit arithmetic unit. The hundreds digit sits in the top nibble, the tens digit in the middle nibble and the units digit in the low nibble. The value is rebuilt with a Horner chain: a running total is multiplied by ten and the next digit is added. Each multiply by ten is done with two shifts and an add, so the datapath has no multipliers.

Along with the value, two validity flags come out. One reports a nibble that is not a legal decimal digit. The other reports a legal number that does not fit the 8-bit operand width. The range test is a small OR over the bits of the full-width total that lie above the operand width. All three results are registered once, behind a synchronous active-high reset, so a consumer sees them one clock edge after it presents the digits.

Top module: `bcd3_to_bin`

## Requirements
- R1: When all three nibbles are legal digits and the decimal value is 255 or less, `bin_out` equals that value after the next rising clock edge. The hundreds digit is `bcd_in[11:8]`, the tens digit is `bcd_in[7:4]` and the units digit is `bcd_in[3:0]`.
- R2: `digit_err` is high after the next rising edge exactly when at least one nibble of `bcd_in` holds a code from 10 to 15.
- R3: With legal digits, `over_range` is high after the next rising edge exactly when the decimal value is greater than 255.
- R4: `over_range` is never high while `digit_err` is high. When a digit is illegal, `bin_out` carries no defined value.
- R5: With legal digits and a value from 256 to 999, `bin_out` holds the low 8 bits of the value, which is the value modulo 256.
- R6: When `rst` is high at a rising edge, `bin_out`, `digit_err` and `over_range` are all zero after that edge, whatever `bcd_in` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4*NDIG (12) | Packed decimal digits, most significant digit in the top nibble |
| bin_out | output | OUT_W (8) | Binary value, low OUT_W bits |
| digit_err | output | 1 | At least one nibble is above 9 |
| over_range | output | 1 | Legal digits, but the value exceeds 2**OUT_W - 1 |

## Verification
Every result is due exactly one rising edge after its digits are sampled, and a reset takes effect at that same single edge. The bench drives a new code on each falling edge. It pushes the expected triple, computed with plain integer arithmetic, onto a queue, and pops and compares it at the following falling edge, when the registered outputs for that code have settled. The full sweep of all 4096 input codes covers the boundaries at 255, 256 and 999 and every illegal nibble position. A reset applied while a legal out-of-range code is held shows that the outputs clear.

// File: rtl/bcd3_pkg.sv
package bcd3_pkg;

    // Width of one decimal digit field
    localparam int DIG_W       = 4;
    // Largest legal digit code
    localparam int DIG_MAX     = 9;
    // Default number of digits and operand width
    localparam int NDIG_DEF    = 3;
    localparam int OUT_W_DEF   = 8;

    // Validity flags travel together through the output register
    typedef struct packed {
        logic bad_digit;
        logic too_big;
    } conv_flags_t;

    // Full-width total needed for NDIG decimal digits
    function automatic int full_width(input int ndig);
        int unsigned lim;
        lim = 1;
        for (int i = 0; i < ndig; i++) lim = lim * 10;
        return $clog2(lim);
    endfunction

endpackage

// File: rtl/bcd3_digit_check.sv
module bcd3_digit_check
    import bcd3_pkg::*;
#(
    parameter int NDIG = NDIG_DEF,
    localparam int IN_W = NDIG * DIG_W
) (
    input  logic [IN_W-1:0] bcd,
    output logic [NDIG-1:0] bad_vec,
    output logic            any_bad
);

    // A 4-bit code exceeds 9 when its top bit is set together with bit 2 or bit 1
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [DIG_W-1:0] nib;
        assign nib        = bcd[g*DIG_W +: DIG_W];
        assign bad_vec[g] = nib[3] & (nib[2] | nib[1]);
    end

    assign any_bad = |bad_vec;

endmodule

// File: rtl/bcd3_weight_sum.sv
module bcd3_weight_sum
    import bcd3_pkg::*;
#(
    parameter int NDIG   = NDIG_DEF,
    parameter int FULL_W = 10,
    localparam int IN_W  = NDIG * DIG_W
) (
    input  logic [IN_W-1:0]   bcd,
    output logic [FULL_W-1:0] total
);

    // Horner chain: stage k holds the value of the k most significant digits
    logic [FULL_W-1:0] stage [NDIG+1];

    assign stage[0] = '0;

    for (genvar g = 0; g < NDIG; g++) begin : g_horner
        logic [DIG_W-1:0]  dig;
        logic [FULL_W-1:0] times8;
        logic [FULL_W-1:0] times2;
        assign dig          = bcd[(NDIG-1-g)*DIG_W +: DIG_W];
        assign times8       = stage[g] << 3;
        assign times2       = stage[g] << 1;
        assign stage[g+1]   = times8 + times2 + FULL_W'(dig);
    end

    assign total = stage[NDIG];

endmodule

// File: rtl/bcd3_range_detect.sv
module bcd3_range_detect #(
    parameter int HI_W = 2
) (
    input  logic [HI_W-1:0] upper,
    input  logic            any_bad,
    output logic            too_big
);

    // Any set bit above the operand width means the value does not fit
    assign too_big = ~any_bad & (|upper);

endmodule

// File: rtl/bcd3_to_bin.sv
module bcd3_to_bin
    import bcd3_pkg::*;
#(
    parameter int NDIG  = NDIG_DEF,
    parameter int OUT_W = OUT_W_DEF,
    localparam int IN_W   = NDIG * DIG_W,
    localparam int FULL_W = full_width(NDIG),
    localparam int HI_W   = FULL_W - OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  bcd_in,
    output logic [OUT_W-1:0] bin_out,
    output logic             digit_err,
    output logic             over_range
);

    logic [NDIG-1:0]   bad_vec;
    logic              any_bad;
    logic [FULL_W-1:0] total;
    logic [OUT_W-1:0]  low_part;
    conv_flags_t       flags_d;
    conv_flags_t       flags_q;
    logic [OUT_W-1:0]  bin_q;

    bcd3_digit_check #(.NDIG(NDIG)) u_check (
        .bcd     (bcd_in),
        .bad_vec (bad_vec),
        .any_bad (any_bad)
    );

    bcd3_weight_sum #(.NDIG(NDIG), .FULL_W(FULL_W)) u_sum (
        .bcd   (bcd_in),
        .total (total)
    );

    // The range test exists only when the total is wider than the operand
    if (HI_W > 0) begin : g_range
        logic too_big;
        bcd3_range_detect #(.HI_W(HI_W)) u_range (
            .upper   (total[FULL_W-1:OUT_W]),
            .any_bad (any_bad),
            .too_big (too_big)
        );
        assign low_part        = total[OUT_W-1:0];
        assign flags_d.too_big = too_big;
    end else begin : g_fits
        assign low_part        = OUT_W'(total);
        assign flags_d.too_big = 1'b0;
    end

    assign flags_d.bad_digit = any_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q   <= '0;
            flags_q <= '0;
        end else begin
            bin_q   <= low_part;
            flags_q <= flags_d;
        end
    end

    assign bin_out    = bin_q;
    assign digit_err  = flags_q.bad_digit;
    assign over_range = flags_q.too_big;

    // ---------------- assertions ----------------
    // Independent decimal model: integer multiply per digit
    logic [31:0] ref_val;
    logic        ref_bad;
    localparam logic [31:0] MAXV = (32'd1 << OUT_W) - 32'd1;

    always_comb begin
        ref_val = '0;
        ref_bad = 1'b0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            ref_val = ref_val * 32'd10 + 32'(bcd_in[i*DIG_W +: DIG_W]);
            if (int'(bcd_in[i*DIG_W +: DIG_W]) > DIG_MAX) ref_bad = 1'b1;
        end
    end

    // R1
    a_r1_value_in_range: assert property (@(posedge clk) disable iff (rst)
        (!ref_bad && ref_val <= MAXV) |=> bin_out == $past(ref_val[OUT_W-1:0]));

    // R2
    a_r2_digit_error: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> digit_err == $past(ref_bad));

    // R3
    a_r3_range_flag: assert property (@(posedge clk) disable iff (rst)
        !ref_bad |=> over_range == $past(ref_val > MAXV));

    // R4
    a_r4_range_masked: assert property (@(posedge clk) disable iff (rst)
        digit_err |-> !over_range);

    // R5
    a_r5_low_bits: assert property (@(posedge clk) disable iff (rst)
        (!ref_bad && ref_val > MAXV) |=> bin_out == $past(ref_val[OUT_W-1:0]));

endmodule

// File: tb/bcd3_to_bin_tb.sv
module bcd3_to_bin_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bcd_in = '0;
    logic [7:0]  bin_out;
    logic        digit_err;
    logic        over_range;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int code;
        int val;
        bit err;
        bit over;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    bcd3_to_bin u_dut (
        .clk        (clk),
        .rst        (rst),
        .bcd_in     (bcd_in),
        .bin_out    (bin_out),
        .digit_err  (digit_err),
        .over_range (over_range)
    );

    function automatic exp_t model(input int code);
        exp_t e;
        int h, t, u;
        h = (code / 256) % 16;
        t = (code / 16) % 16;
        u = code % 16;
        e.code = code;
        e.err  = (h > 9) || (t > 9) || (u > 9);
        e.val  = h * 100 + t * 10 + u;
        e.over = !e.err && (e.val > 255);
        return e;
    endfunction

    task automatic check_one(input exp_t e);
        // R2: digit error flag
        n_tests++;
        if (digit_err !== e.err) begin
            n_fail++;
            $display("FAIL R2 code=%03h digit_err=%0b expected %0b", e.code, digit_err, e.err);
        end
        // R3 for legal digits, R4 when a digit is illegal
        n_tests++;
        if (over_range !== e.over) begin
            n_fail++;
            if (e.err)
                $display("FAIL R4 code=%03h over_range=%0b expected %0b", e.code, over_range, e.over);
            else
                $display("FAIL R3 code=%03h over_range=%0b expected %0b", e.code, over_range, e.over);
        end
        // R1 for values up to 255, R5 above
        if (!e.err) begin
            n_tests++;
            if (int'(bin_out) != (e.val % 256)) begin
                n_fail++;
                if (e.val <= 255)
                    $display("FAIL R1 code=%03h bin_out=%0d expected %0d", e.code, bin_out, e.val);
                else
                    $display("FAIL R5 code=%03h bin_out=%0d expected %0d", e.code, bin_out, e.val % 256);
            end
        end
    endtask

    task automatic check_reset(input string where);
        // R6: reset clears every output
        n_tests++;
        if (bin_out !== 8'd0 || digit_err !== 1'b0 || over_range !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 %s bin_out=%0d err=%0b over=%0b expected 0 0 0",
                     where, bin_out, digit_err, over_range);
        end
    endtask

    // One step per clock: compare what was due, then drive the next code
    task automatic step(input int code, input bit push);
        @(negedge clk);
        if (q.size() > 0) check_one(q.pop_front());
        bcd_in = code[11:0];
        if (push) q.push_back(model(code));
    endtask

    initial begin
        bcd_in = 12'h999;
        rst    = 1'b1;
        repeat (3) @(negedge clk);
        check_reset("after power-up");

        @(negedge clk);
        rst = 1'b0;
        // Full sweep of every input code (R1..R5)
        for (int c = 0; c < 4096; c++) step(c, 1'b1);
        // Boundary codes again, back to back
        step(12'h255, 1'b1);
        step(12'h256, 1'b1);
        step(12'h000, 1'b1);
        step(12'h999, 1'b1);
        step(12'hA00, 1'b1);
        step(12'h0F0, 1'b1);
        step(12'h00A, 1'b1);
        step(12'h999, 1'b0);

        // Reset while a legal out-of-range code is held (R6)
        rst = 1'b1;
        @(negedge clk);
        check_reset("mid-run");
        rst = 1'b0;
        step(12'h999, 1'b1);
        step(12'h128, 1'b1);
        step(12'h000, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 200000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired before the run completed");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule